// File: doc/BRIEF.md
# Auxiliary Memory DMA Engine with Fixed-Priority Bus Arbiter

This block copies data between main memory and an auxiliary SDRAM in 32-byte units, and shares the 64-bit auxiliary memory bus among three requesters. The host sets up the transfer through six 16-bit register halves: a main-memory address, an auxiliary address and a byte length. The length's upper half also carries the direction bit. A write to the lower length half starts the transfer. Each unit is staged in a four-beat buffer. The engine first fills the buffer from the source side and then drains it to the destination side. After each unit the length register counts down and both address registers count up.

The auxiliary bus is granted by a fixed priority. The refresh requester comes first, then the accelerator requester, then the DMA. The DMA only asks for the bus during the auxiliary half of a unit. It can lose the bus at any 64-bit beat, and it continues from that same beat once the bus is free again. Both memory sides are single-cycle beat ports. Read data returns in the same cycle as the beat, and a write beat is taken at the clock edge that ends it.

Top module: `aux_dma_top`

## Requirements
- R1: The low 5 bits of the main-memory address, the auxiliary address and the length are always zero. A written value reads back with those bits cleared.
- R2: A host write to index 5 (length low half) while idle starts a transfer, and busy_o is high on the next cycle when the new length is nonzero.
- R3: Bit 15 of index 4 (length high half) selects the direction. 0 copies main memory into auxiliary memory, and 1 copies auxiliary memory into main memory. Bits 14:0 of index 4 are length bits 30:16.
- R4: Each 32-byte unit makes exactly four main-memory beats and four auxiliary beats at addresses base+0, +8, +16 and +24. The destination ends up holding the source data word for word.
- R5: After each unit the length falls by 32 and both addresses rise by 32. Once the transfer is complete, the registers read a length of 0 and each address equal to its start value plus 32 times the number of units.
- R6: Grants follow a fixed priority with at most one grant per cycle. A refresh request is always granted. An accelerator request is granted only when refresh is not requesting. The DMA is granted only when neither of the others is requesting.
- R7: No DMA auxiliary beat occurs in a cycle in which refresh or the accelerator is requesting. A preempted unit resumes at the beat it had reached and loses no data.
- R8: done_o pulses for exactly one cycle when the length reaches 0, and busy_o falls at the same edge.
- R9: A start with a length of 0 pulses done_o on the next cycle, keeps busy_o low and makes no bus beat.
- R10: Host register writes made while busy_o is high are ignored.
- R11: After reset all registers read 0, busy_o and done_o are low, and no beat is issued.
- Register indices: 0 and 1 are the high and low halves of the main-memory address, 2 and 3 are the high and low halves of the auxiliary address, and 4 and 5 are the high and low halves of the length. Indices 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 3 | Register half index |
| reg_wdata_i | input | 16 | Host write data |
| reg_rdata_o | output | 16 | Read data of the indexed half |
| ref_req_i | input | 1 | Refresh bus request |
| ref_gnt_o | output | 1 | Refresh bus grant |
| acc_req_i | input | 1 | Accelerator bus request |
| acc_gnt_o | output | 1 | Accelerator bus grant |
| aux_valid_o | output | 1 | DMA auxiliary beat this cycle |
| aux_we_o | output | 1 | Auxiliary beat is a write |
| aux_addr_o | output | 32 | Auxiliary beat byte address |
| aux_wdata_o | output | DATA_W | Auxiliary write data |
| aux_rdata_i | input | DATA_W | Auxiliary read data, same cycle |
| mm_valid_o | output | 1 | Main-memory beat this cycle |
| mm_we_o | output | 1 | Main-memory beat is a write |
| mm_addr_o | output | 32 | Main-memory beat byte address |
| mm_wdata_o | output | DATA_W | Main-memory write data |
| mm_rdata_i | input | DATA_W | Main-memory read data, same cycle |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse (interrupt source) |

## Verification
A wrong beat index or buffer slot shows up as a misplaced or stale 64-bit word in the destination memory by the end of the unit, so each transfer is followed by a comparison of the whole memory. A wrong length or address stepping shows up in the register readback after done_o, or as a wrong beat count: the transfer ends one or more units early or late. A priority fault shows up in the first cycle where two requests overlap, because grants are compared against the requests in every cycle of every transfer.

// File: rtl/aux_dma_pkg.sv
package aux_dma_pkg;
  localparam int ADDR_W = 32;
  localparam int SIZE_W = 31;
  localparam int HALF_W = 16;

  typedef enum logic [2:0] {
    RI_MM_HI  = 3'd0,
    RI_MM_LO  = 3'd1,
    RI_AUX_HI = 3'd2,
    RI_AUX_LO = 3'd3,
    RI_LEN_HI = 3'd4,
    RI_LEN_LO = 3'd5
  } reg_idx_e;

  typedef enum logic {PH_FILL = 1'b0, PH_DRAIN = 1'b1} phase_e;
endpackage

// File: rtl/aux_bus_arbiter.sv
module aux_bus_arbiter #(
  parameter int N_REQ = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_i,
  output logic [N_REQ-1:0] gnt_o
);
  // index 0 has highest priority: isolate lowest set bit
  assign gnt_o = req_i & (~req_i + N_REQ'(1));

  // R6
  onehot_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R6
  top_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[0] |-> gnt_o[0]);
  // R6
  no_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |-> (gnt_o != '0));
endmodule

// File: rtl/aux_dma_regs.sv
module aux_dma_regs
  import aux_dma_pkg::*;
#(
  parameter int ALIGN_W    = 5,
  parameter int UNIT_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              step_i,
  output logic              start_o,
  output logic              start_zero_o,
  output logic              last_unit_o,
  output logic              dir_o,
  output logic [ADDR_W-1:0] mm_addr_o,
  output logic [ADDR_W-1:0] aux_addr_o
);
  localparam logic [ADDR_W-1:0] AMASK = ~ADDR_W'((1 << ALIGN_W) - 1);
  localparam logic [SIZE_W-1:0] SMASK = ~SIZE_W'((1 << ALIGN_W) - 1);

  logic [ADDR_W-1:0] mm_q, aux_q;
  logic [SIZE_W-1:0] size_q, size_new;
  logic              dir_q, wr_ok;

  assign wr_ok    = we_i && !busy_i;
  assign size_new = {size_q[SIZE_W-1:HALF_W], wdata_i} & SMASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mm_q   <= '0;
      aux_q  <= '0;
      size_q <= '0;
      dir_q  <= 1'b0;
    end else if (step_i) begin
      mm_q   <= mm_q + ADDR_W'(UNIT_BYTES);
      aux_q  <= aux_q + ADDR_W'(UNIT_BYTES);
      size_q <= size_q - SIZE_W'(UNIT_BYTES);
    end else if (wr_ok) begin
      case (addr_i)
        RI_MM_HI:  mm_q[ADDR_W-1:HALF_W]  <= wdata_i;
        RI_MM_LO:  mm_q[HALF_W-1:0]       <= wdata_i & AMASK[HALF_W-1:0];
        RI_AUX_HI: aux_q[ADDR_W-1:HALF_W] <= wdata_i;
        RI_AUX_LO: aux_q[HALF_W-1:0]      <= wdata_i & AMASK[HALF_W-1:0];
        RI_LEN_HI: begin
          dir_q                  <= wdata_i[HALF_W-1];
          size_q[SIZE_W-1:HALF_W] <= wdata_i[HALF_W-2:0];
        end
        RI_LEN_LO: size_q <= size_new;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      RI_MM_HI:  rdata_o = mm_q[ADDR_W-1:HALF_W];
      RI_MM_LO:  rdata_o = mm_q[HALF_W-1:0];
      RI_AUX_HI: rdata_o = aux_q[ADDR_W-1:HALF_W];
      RI_AUX_LO: rdata_o = aux_q[HALF_W-1:0];
      RI_LEN_HI: rdata_o = {dir_q, size_q[SIZE_W-1:HALF_W]};
      RI_LEN_LO: rdata_o = size_q[HALF_W-1:0];
      default:   rdata_o = '0;
    endcase
  end

  assign start_o      = wr_ok && (addr_i == RI_LEN_LO);
  assign start_zero_o = (size_new == '0);
  assign last_unit_o  = (size_q == SIZE_W'(UNIT_BYTES));
  assign dir_o        = dir_q;
  assign mm_addr_o    = mm_q;
  assign aux_addr_o   = aux_q;

  // R5
  size_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> size_q == $past(size_q) - SIZE_W'(UNIT_BYTES));
  // R5
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> aux_q == $past(aux_q) + ADDR_W'(UNIT_BYTES));
  // R10
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(dir_q));
endmodule

// File: rtl/aux_dma_engine.sv
module aux_dma_engine
  import aux_dma_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int UNIT_BEATS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              start_zero_i,
  input  logic              last_unit_i,
  input  logic              dir_i,
  input  logic [ADDR_W-1:0] mm_base_i,
  input  logic [ADDR_W-1:0] aux_base_i,
  output logic              step_o,
  output logic              dma_req_o,
  input  logic              dma_gnt_i,
  output logic              aux_valid_o,
  output logic              aux_we_o,
  output logic [ADDR_W-1:0] aux_addr_o,
  output logic [DATA_W-1:0] aux_wdata_o,
  input  logic [DATA_W-1:0] aux_rdata_i,
  output logic              mm_valid_o,
  output logic              mm_we_o,
  output logic [ADDR_W-1:0] mm_addr_o,
  output logic [DATA_W-1:0] mm_wdata_o,
  input  logic [DATA_W-1:0] mm_rdata_i,
  output logic              busy_o,
  output logic              done_o
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int BIDX_W     = $clog2(UNIT_BEATS);

  logic              busy_q, done_q;
  phase_e            phase_q;
  logic [BIDX_W-1:0] beat_q;
  logic [DATA_W-1:0] buf_q [UNIT_BEATS];
  logic              aux_phase, fire, last_beat;
  logic [ADDR_W-1:0] beat_off;

  // dir 0: fill from main memory, drain to aux; dir 1: the reverse
  assign aux_phase = dir_i ? (phase_q == PH_FILL) : (phase_q == PH_DRAIN);
  assign fire      = busy_q && (!aux_phase || dma_gnt_i);
  assign last_beat = (beat_q == BIDX_W'(UNIT_BEATS - 1));
  assign step_o    = fire && (phase_q == PH_DRAIN) && last_beat;
  assign beat_off  = ADDR_W'(beat_q) * ADDR_W'(BEAT_BYTES);

  assign dma_req_o   = busy_q && aux_phase;
  assign aux_valid_o = busy_q && aux_phase && dma_gnt_i;
  assign aux_we_o    = !dir_i;
  assign aux_addr_o  = aux_base_i + beat_off;
  assign aux_wdata_o = buf_q[beat_q];
  assign mm_valid_o  = busy_q && !aux_phase;
  assign mm_we_o     = dir_i;
  assign mm_addr_o   = mm_base_i + beat_off;
  assign mm_wdata_o  = buf_q[beat_q];
  assign busy_o      = busy_q;
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      phase_q <= PH_FILL;
      beat_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        if (start_zero_i) done_q <= 1'b1;
        else              busy_q <= 1'b1;
        phase_q <= PH_FILL;
        beat_q  <= '0;
      end else if (fire) begin
        beat_q <= last_beat ? '0 : beat_q + BIDX_W'(1);
        if (last_beat) begin
          phase_q <= (phase_q == PH_FILL) ? PH_DRAIN : PH_FILL;
          if (phase_q == PH_DRAIN && last_unit_i) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < UNIT_BEATS; i++) buf_q[i] <= '0;
    end else if (fire && phase_q == PH_FILL) begin
      buf_q[beat_q] <= dir_i ? aux_rdata_i : mm_rdata_i;
    end
  end

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

// File: rtl/aux_dma_top.sv
module aux_dma_top
  import aux_dma_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int UNIT_BEATS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  input  logic              ref_req_i,
  output logic              ref_gnt_o,
  input  logic              acc_req_i,
  output logic              acc_gnt_o,
  output logic              aux_valid_o,
  output logic              aux_we_o,
  output logic [31:0]       aux_addr_o,
  output logic [DATA_W-1:0] aux_wdata_o,
  input  logic [DATA_W-1:0] aux_rdata_i,
  output logic              mm_valid_o,
  output logic              mm_we_o,
  output logic [31:0]       mm_addr_o,
  output logic [DATA_W-1:0] mm_wdata_o,
  input  logic [DATA_W-1:0] mm_rdata_i,
  output logic              busy_o,
  output logic              done_o
);
  localparam int UNIT_BYTES = UNIT_BEATS * DATA_W / 8;
  localparam int ALIGN_W    = $clog2(UNIT_BYTES);

  logic              start, start_zero, last_unit, dir, step, dma_req, busy;
  logic [ADDR_W-1:0] mm_base, aux_base;
  logic [2:0]        req, gnt;

  assign req       = {dma_req, acc_req_i, ref_req_i};
  assign ref_gnt_o = gnt[0];
  assign acc_gnt_o = gnt[1];
  assign busy_o    = busy;

  aux_bus_arbiter #(.N_REQ(3)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .gnt_o(gnt)
  );

  aux_dma_regs #(.ALIGN_W(ALIGN_W), .UNIT_BYTES(UNIT_BYTES)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .busy_i(busy),
    .step_i(step), .start_o(start), .start_zero_o(start_zero),
    .last_unit_o(last_unit), .dir_o(dir), .mm_addr_o(mm_base),
    .aux_addr_o(aux_base)
  );

  aux_dma_engine #(.DATA_W(DATA_W), .UNIT_BEATS(UNIT_BEATS)) u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start),
    .start_zero_i(start_zero), .last_unit_i(last_unit), .dir_i(dir),
    .mm_base_i(mm_base), .aux_base_i(aux_base), .step_o(step),
    .dma_req_o(dma_req), .dma_gnt_i(gnt[2]), .aux_valid_o(aux_valid_o),
    .aux_we_o(aux_we_o), .aux_addr_o(aux_addr_o), .aux_wdata_o(aux_wdata_o),
    .aux_rdata_i(aux_rdata_i), .mm_valid_o(mm_valid_o), .mm_we_o(mm_we_o),
    .mm_addr_o(mm_addr_o), .mm_wdata_o(mm_wdata_o), .mm_rdata_i(mm_rdata_i),
    .busy_o(busy), .done_o(done_o)
  );

  // R7
  dma_yield_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_valid_o |-> !ref_req_i && !acc_req_i);
  // R9
  zero_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && start_zero) |=> done_o && !busy_o && !mm_valid_o);
endmodule

// File: tb/tb_aux_dma_top.sv
module tb_aux_dma_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        ref_req = 1'b0, acc_req = 1'b0, ref_gnt, acc_gnt;
  logic        aux_valid, aux_we, mm_valid, mm_we, busy, done;
  logic [31:0] aux_addr, mm_addr;
  logic [63:0] aux_wdata, aux_rdata, mm_wdata, mm_rdata;
  logic [63:0] mm_mem [64];
  logic [63:0] aux_mem [64];
  int checks = 0, fails = 0, cyc = 0, pat = 0;

  always #5 clk = ~clk;

  aux_dma_top dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ref_req_i(ref_req),
    .ref_gnt_o(ref_gnt), .acc_req_i(acc_req), .acc_gnt_o(acc_gnt),
    .aux_valid_o(aux_valid), .aux_we_o(aux_we), .aux_addr_o(aux_addr),
    .aux_wdata_o(aux_wdata), .aux_rdata_i(aux_rdata), .mm_valid_o(mm_valid),
    .mm_we_o(mm_we), .mm_addr_o(mm_addr), .mm_wdata_o(mm_wdata),
    .mm_rdata_i(mm_rdata), .busy_o(busy), .done_o(done)
  );

  assign mm_rdata  = mm_mem[mm_addr[8:3]];
  assign aux_rdata = aux_mem[aux_addr[8:3]];

  always @(posedge clk) begin
    if (mm_valid && mm_we)   mm_mem[mm_addr[8:3]]   <= mm_wdata;
    if (aux_valid && aux_we) aux_mem[aux_addr[8:3]] <= aux_wdata;
  end

  // request patterns change just after the edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2;
    ref_req = (pat == 1) ? (cyc % 4 == 0) : (pat == 2) ? (cyc % 5 == 0) : 1'b0;
    acc_req = (pat == 2) ? (cyc % 3 != 0) : 1'b0;
  end

  function automatic logic [63:0] mm_init(int k);
    return {32'hA0A0_0000 | 32'(k), 32'h0000_1000 + 32'(k * 7)};
  endfunction
  function automatic logic [63:0] aux_init(int k);
    return {32'hC3C3_0000 | 32'(k), ~32'(k)};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [15:0] d);
    addr = 3'(idx); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [15:0] d);
    addr = 3'(idx); #1; d = rdata;
  endtask

  task automatic run(input int dir, input int units, input int p);
    int mb, ab, n, naux, nmm, bad, ndone;
    logic [15:0] v;
    logic [63:0] e;
    mb = 32 * (p + 1);
    ab = 32 * (units + 4);
    for (int k = 0; k < 64; k++) begin mm_mem[k] = mm_init(k); aux_mem[k] = aux_init(k); end
    pat = p;
    wr(0, 16'h0); wr(1, 16'(mb)); wr(2, 16'h0); wr(3, 16'(ab));
    wr(4, {1'(dir), 15'h0});
    wr(5, 16'(units * 32));
    // R2 R9: state one cycle after the start edge
    chk(busy == (units != 0), "R2 busy after start", busy, units != 0);
    chk(done == (units == 0), "R9 done after zero start", done, units == 0);
    n = 0; naux = 0; nmm = 0; ndone = 0; bad = 0;
    while (ndone == 0 && n < 1000) begin
      if (aux_valid) naux++;
      if (mm_valid) nmm++;
      if (ref_gnt != ref_req || acc_gnt != (acc_req && !ref_req)) bad++;  // R6
      if (aux_valid && (ref_req || acc_req)) bad++;                       // R7
      if (done) begin
        ndone++;
        chk(!busy, "R8 busy low at done", busy, 0);
      end
      if (n == 2 && busy) begin
        addr = 3'd1; wdata = 16'h7FE0; we = 1'b1;  // R10: ignored write
      end else we = 1'b0;
      n++;
      @(negedge clk);
    end
    we = 1'b0;
    chk(ndone == 1, "R8 one done pulse", ndone, 1);
    chk(!done, "R8 done single cycle", done, 0);
    chk(bad == 0, "R6 R7 grant priority", bad, 0);
    chk(naux == units * 4, "R4 aux beat count", naux, units * 4);
    chk(nmm == units * 4, "R4 mm beat count", nmm, units * 4);
    rd(5, v); chk(v == 16'h0, "R5 length low at end", v, 0);
    rd(4, v); chk(v == {1'(dir), 15'h0}, "R3 length high at end", v, {1'(dir), 15'h0});
    rd(1, v); chk(v == 16'(mb + 32 * units), "R5 R10 mm addr at end", v, mb + 32 * units);
    rd(3, v); chk(v == 16'(ab + 32 * units), "R5 aux addr at end", v, ab + 32 * units);
    bad = 0;
    for (int k = 0; k < 64; k++) begin
      if (dir == 0) begin
        e = (k >= ab / 8 && k < ab / 8 + units * 4) ? mm_init(mb / 8 + k - ab / 8) : aux_init(k);
        if (aux_mem[k] !== e) bad++;
        if (mm_mem[k] !== mm_init(k)) bad++;
      end else begin
        e = (k >= mb / 8 && k < mb / 8 + units * 4) ? aux_init(ab / 8 + k - mb / 8) : mm_init(k);
        if (mm_mem[k] !== e) bad++;
        if (aux_mem[k] !== aux_init(k)) bad++;
      end
    end
    chk(bad == 0, dir ? "R3 R4 R7 aux to mm data" : "R3 R4 R7 mm to aux data", bad, 0);
    pat = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R11 reset state
    for (int i = 0; i < 8; i++) begin
      rd(i, v); chk(v == 16'h0, "R11 register reset", v, 0);
    end
    chk(!busy && !done && !mm_valid && !aux_valid, "R11 outputs idle",
        {busy, done, mm_valid, aux_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 alignment masking
    wr(1, 16'h123F); rd(1, v); chk(v == 16'h1220, "R1 mm low masked", v, 16'h1220);
    wr(3, 16'hFFFF); rd(3, v); chk(v == 16'hFFE0, "R1 aux low masked", v, 16'hFFE0);
    wr(0, 16'hBEEF); rd(0, v); chk(v == 16'hBEEF, "R1 mm high kept", v, 16'hBEEF);
    wr(4, 16'h0000); wr(5, 16'h001F);
    chk(done && !busy, "R1 R9 sub-unit length is zero", {done, busy}, 2'b10);
    rd(5, v); chk(v == 16'h0, "R1 length low masked", v, 0);
    // sweep direction, unit count and preemption pattern
    for (int d = 0; d < 2; d++)
      for (int u = 0; u < 4; u++)
        for (int p = 0; p < 3; p++)
          run(d, u, p);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule